// File: doc/BRIEF.md
# Noise Source Health Monitor

This block sits beside a hardware noise source. It watches the serial raw bit stream, one bit per `bitValid` strobe, and runs statistical health tests on it all the time. Three of the tests look at fixed windows of `BLOCK_BITS` accepted bits:

- **Ones balance:** the count of ones in the window.
- **Pattern distribution:** sixteen counters, one per 4-bit pattern.
- **Run distribution:** run-length bins, kept separately for runs of ones and runs of zeros.

Two more tests follow the stream without window boundaries. A run of `LONG_RUN` identical bits is flagged at once. A longer run of `NOISE_RUN` identical bits raises a separate noise flag. The assembled output words arrive on `wordValid`/`wordIn`, and a word that equals the word before it raises the stuck-output flag.

Each test has its own sticky failure flag, which only `clearFlags` or reset can drop. When a window closes, the block scores the window over 17 cycles: one cycle per pattern counter, then one final cycle. After that it starts a fresh window. Every threshold is a parameter.

Top module: `rng_health_monitor`

## Requirements
- R1: Ones balance. At the close of each window, `failMonobit` is set unless the number of ones among the window's `BLOCK_BITS` bits is strictly above `MONO_LO` and strictly below `MONO_HI`.
- R2: Pattern distribution.
  - Each group of 4 consecutive window bits forms one pattern value, with the first bit taken as the most significant.
  - At window close, `failPoker` is set if any of the 16 pattern counts lies outside [`POKER_CNT_LO`, `POKER_CNT_HI`].
  - It is also set if the sum of the squared counts is not strictly between `POKER_SQ_LO` and `POKER_SQ_HI`.
- R3: Run distribution.
  - Runs inside a window are binned by length 1 to `RUN_BINS`-1, plus one bin for `RUN_BINS` or longer, with separate bins for ones and for zeros.
  - A run closes on a differing bit or at the window's last bit, and no run carries over into the next window.
  - At window close, `failRuns` is set if any bin of length index k lies outside [`RUN_LO[k]`, `RUN_HI[k]`], for either polarity.
- R4: Long run. `failLongRun` is set at the clock edge that accepts a bit making the current run of identical bits `LONG_RUN` or longer. This test ignores window boundaries.
- R5: Noise run. `failNoise` is set at the clock edge that accepts a bit making the current run `NOISE_RUN` or longer. This test ignores window boundaries.
- R6: Stuck output. `failStuck` is set at the edge where `wordValid` carries a word equal to the previous word accepted on `wordValid` since reset.
- R7: Window timing.
  - The window verdicts (R1 to R3) appear on the flags 17 clock edges after the edge that accepts the window's last bit.
  - Bits presented during those 17 edges are left out of every window, but they still feed R4 and R5.
  - The next window starts with the first bit accepted after that.
- R8: Sticky flags. Every flag stays set until a `clearFlags` edge clears it. A failure detected on that same edge keeps or sets its flag.
- R9: Reset. Reset clears every flag and all window, run and word history.
- R10: Run length. The run length restarts at 1 on a bit that differs from the previous bit. It saturates rather than wraps, so a run that continues far past `NOISE_RUN` keeps flagging R4 and R5 after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearFlags | input | 1 | Clears all failure flags at this edge |
| bitValid | input | 1 | A raw bit is present on `bitIn` |
| bitIn | input | 1 | Raw noise bit |
| wordValid | input | 1 | An assembled output word is present on `wordIn` |
| wordIn | input | WORD_W | Assembled output word |
| failMonobit | output | 1 | Sticky ones-balance failure (R1) |
| failPoker | output | 1 | Sticky pattern-distribution failure (R2) |
| failRuns | output | 1 | Sticky run-distribution failure (R3) |
| failLongRun | output | 1 | Sticky long-run failure (R4) |
| failNoise | output | 1 | Sticky noise-run failure (R5) |
| failStuck | output | 1 | Sticky repeated-word failure (R6) |

## Verification
The continuous results are due one edge after the stimulus: the long-run, noise and stuck flags are registered on the edge that accepts the offending bit or word. The window verdicts are due exactly 17 edges after the edge that accepts a window's last bit.

The bench advances a reference model at every rising edge, using the values it drove. The model holds its pending window verdicts for those 17 edges and also leaves out the bits that arrive in that gap. All six flags are compared against the model at every falling edge, so an early or late flag counts as a mismatch in the cycle it occurs.

// File: rtl/rng_hm_pkg.sv
package rng_hm_pkg;

  localparam int FL_MONO   = 0;
  localparam int FL_POKER  = 1;
  localparam int FL_RUNS   = 2;
  localparam int FL_LONG   = 3;
  localparam int FL_NOISE  = 4;
  localparam int FL_STUCK  = 5;
  localparam int FLAG_CNT  = 6;

  localparam int PATTERN_BITS = 4;
  localparam int PATTERN_CNT  = 1 << PATTERN_BITS;

  typedef enum logic [1:0] {
    ST_ACC,
    ST_EVAL,
    ST_FINAL
  } ctlState_e;

  typedef struct packed {
    logic                    winAccept;
    logic                    winFirst;
    logic                    nibbleEnd;
    logic                    lastBit;
    logic                    evalStep;
    logic [PATTERN_BITS-1:0] pokIdx;
    logic                    finalize;
  } ctlStrobe_t;

endpackage

// File: rtl/rng_hm_control.sv
module rng_hm_control
  import rng_hm_pkg::*;
#(
  parameter int BLOCK_BITS = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(BLOCK_BITS);

  ctlState_e               state;
  logic [CNT_W-1:0]        bitCnt;
  logic [PATTERN_BITS-1:0] evalIdx;

  always_comb begin
    strobe           = '0;
    strobe.winAccept = (state == ST_ACC) && bitValid;
    strobe.winFirst  = (bitCnt == '0);
    strobe.nibbleEnd = (bitCnt[1:0] == 2'b11);
    strobe.lastBit   = strobe.winAccept && (bitCnt == CNT_W'(BLOCK_BITS - 1));
    strobe.evalStep  = (state == ST_EVAL);
    strobe.pokIdx    = evalIdx;
    strobe.finalize  = (state == ST_FINAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ACC;
      bitCnt  <= '0;
      evalIdx <= '0;
    end else begin
      unique case (state)
        ST_ACC: begin
          if (strobe.winAccept) begin
            if (strobe.lastBit) begin
              bitCnt  <= '0;
              evalIdx <= '0;
              state   <= ST_EVAL;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_EVAL: begin
          evalIdx <= evalIdx + 1'b1;
          if (evalIdx == PATTERN_BITS'(PATTERN_CNT - 1)) state <= ST_FINAL;
        end
        ST_FINAL: state <= ST_ACC;
        default:  state <= ST_ACC;
      endcase
    end
  end

  // Scoring begins on the edge right after a window closes.
  AST_EVAL_FOLLOWS_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastBit |=> (strobe.evalStep && strobe.pokIdx == '0)); // R7

  // Once finalized, the next window starts from its first bit.
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finalize |=> (!strobe.evalStep && strobe.winFirst)); // R7

endmodule

// File: rtl/rng_hm_datapath.sv
module rng_hm_datapath
  import rng_hm_pkg::*;
#(
  parameter int BLOCK_BITS   = 20000,
  parameter int WORD_W       = 32,
  parameter int MONO_LO      = 9654,
  parameter int MONO_HI      = 10346,
  parameter int POKER_CNT_LO = 0,
  parameter int POKER_CNT_HI = 5000,
  parameter int POKER_SQ_LO  = 1562822,
  parameter int POKER_SQ_HI  = 1580437,
  parameter int RUN_BINS     = 6,
  parameter int RUN_LO [RUN_BINS] = '{2267, 1079, 502, 223, 90, 90},
  parameter int RUN_HI [RUN_BINS] = '{2733, 1421, 748, 402, 223, 223},
  parameter int LONG_RUN     = 34,
  parameter int NOISE_RUN    = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic                clearFlags,
  input  logic                bitValid,
  input  logic                bitIn,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordIn,
  output logic [FLAG_CNT-1:0] failVec
);

  localparam int RUN_W  = $clog2(NOISE_RUN + 1);
  localparam int WCNT_W = $clog2(BLOCK_BITS + 1);
  localparam int PCNT_W = $clog2(BLOCK_BITS / PATTERN_BITS + 1);
  localparam int SQ_W   = 2 * PCNT_W + PATTERN_BITS;
  localparam int BIN_W  = $clog2(RUN_BINS + 1);

  // ---------------- continuous run tracking ----------------
  logic             prevBit, haveBit;
  logic [RUN_W-1:0] runLen, nextRun;
  logic             longHit, noiseHit;

  always_comb begin
    if (haveBit && (bitIn == prevBit))
      nextRun = (runLen == RUN_W'(NOISE_RUN)) ? runLen : runLen + 1'b1;
    else
      nextRun = RUN_W'(1);
  end

  assign longHit  = bitValid && (nextRun >= RUN_W'(LONG_RUN));
  assign noiseHit = bitValid && (nextRun >= RUN_W'(NOISE_RUN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit <= 1'b0;
      haveBit <= 1'b0;
      runLen  <= '0;
    end else if (bitValid) begin
      prevBit <= bitIn;
      haveBit <= 1'b1;
      runLen  <= nextRun;
    end
  end

  // ---------------- ones count ----------------
  logic [WCNT_W-1:0] onesCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          onesCnt <= '0;
    else if (strobe.finalize)           onesCnt <= '0;
    else if (strobe.winAccept && bitIn) onesCnt <= onesCnt + 1'b1;
  end

  // ---------------- pattern counters ----------------
  logic [PATTERN_BITS-2:0] nibShift;
  logic [PATTERN_BITS-1:0] nibVal;
  logic [PCNT_W-1:0]       pokerCnt [PATTERN_CNT];

  assign nibVal = {nibShift, bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 nibShift <= '0;
    else if (strobe.winAccept) nibShift <= nibVal[PATTERN_BITS-2:0];
  end

  for (genvar g = 0; g < PATTERN_CNT; g++) begin : gPoker
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        pokerCnt[g] <= '0;
      else if (strobe.finalize)
        pokerCnt[g] <= '0;
      else if (strobe.winAccept && strobe.nibbleEnd && nibVal == PATTERN_BITS'(g))
        pokerCnt[g] <= pokerCnt[g] + 1'b1;
    end
  end

  // ---------------- window run bins ----------------
  logic             sameW;
  logic [BIN_W-1:0] winRun, newWinRun;
  logic             tallyA, tallyB;
  logic [WCNT_W-1:0] binOne  [RUN_BINS];
  logic [WCNT_W-1:0] binZero [RUN_BINS];

  assign sameW     = !strobe.winFirst && (bitIn == prevBit);
  assign newWinRun = !sameW ? BIN_W'(1)
                   : (winRun == BIN_W'(RUN_BINS)) ? winRun : winRun + BIN_W'(1);
  // A closes the run that a differing bit ends; B closes the run ending at the window's last bit.
  assign tallyA    = strobe.winAccept && !strobe.winFirst && !sameW;
  assign tallyB    = strobe.lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winRun <= '0;
    else if (strobe.winAccept) winRun <= newWinRun;
  end

  for (genvar k = 0; k < RUN_BINS; k++) begin : gRunBin
    logic incOne, incZero;
    assign incOne  = (tallyA &&  prevBit && winRun    == BIN_W'(k + 1)) ||
                     (tallyB &&  bitIn   && newWinRun == BIN_W'(k + 1));
    assign incZero = (tallyA && !prevBit && winRun    == BIN_W'(k + 1)) ||
                     (tallyB && !bitIn   && newWinRun == BIN_W'(k + 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        binOne[k]  <= '0;
        binZero[k] <= '0;
      end else if (strobe.finalize) begin
        binOne[k]  <= '0;
        binZero[k] <= '0;
      end else begin
        if (incOne)  binOne[k]  <= binOne[k] + 1'b1;
        if (incZero) binZero[k] <= binZero[k] + 1'b1;
      end
    end
  end

  // ---------------- serial window scoring ----------------
  logic [PCNT_W-1:0] selCnt;
  logic [SQ_W-1:0]   selWide, sumSq;
  logic              pokBad, selBad;
  logic [63:0]       sumWide;

  assign selCnt  = pokerCnt[strobe.pokIdx];
  assign selWide = SQ_W'(selCnt);
  assign selBad  = (32'(selCnt) < 32'(POKER_CNT_LO)) || (32'(selCnt) > 32'(POKER_CNT_HI));
  assign sumWide = 64'(sumSq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumSq  <= '0;
      pokBad <= 1'b0;
    end else if (strobe.finalize) begin
      sumSq  <= '0;
      pokBad <= 1'b0;
    end else if (strobe.evalStep) begin
      sumSq  <= sumSq + selWide * selWide;
      pokBad <= pokBad | selBad;
    end
  end

  logic monoBad, pokerBad, runBad;

  assign monoBad  = !((32'(onesCnt) > 32'(MONO_LO)) && (32'(onesCnt) < 32'(MONO_HI)));
  assign pokerBad = pokBad || !((sumWide > 64'(POKER_SQ_LO)) && (sumWide < 64'(POKER_SQ_HI)));

  always_comb begin
    runBad = 1'b0;
    for (int k = 0; k < RUN_BINS; k++) begin
      if (32'(binOne[k])  < 32'(RUN_LO[k]) || 32'(binOne[k])  > 32'(RUN_HI[k])) runBad = 1'b1;
      if (32'(binZero[k]) < 32'(RUN_LO[k]) || 32'(binZero[k]) > 32'(RUN_HI[k])) runBad = 1'b1;
    end
  end

  // ---------------- repeated word ----------------
  logic [WORD_W-1:0] prevWord;
  logic              haveWord, stuckHit;

  assign stuckHit = wordValid && haveWord && (wordIn == prevWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      haveWord <= 1'b0;
    end else if (wordValid) begin
      prevWord <= wordIn;
      haveWord <= 1'b1;
    end
  end

  // ---------------- sticky flags ----------------
  logic [FLAG_CNT-1:0] hitVec;

  always_comb begin
    hitVec           = '0;
    hitVec[FL_MONO]  = strobe.finalize && monoBad;
    hitVec[FL_POKER] = strobe.finalize && pokerBad;
    hitVec[FL_RUNS]  = strobe.finalize && runBad;
    hitVec[FL_LONG]  = longHit;
    hitVec[FL_NOISE] = noiseHit;
    hitVec[FL_STUCK] = stuckHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) failVec <= '0;
    else       failVec <= (clearFlags ? '0 : failVec) | hitVec;
  end

  AST_LONG_RUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && haveBit && bitIn == prevBit && runLen >= RUN_W'(LONG_RUN - 1))
      |=> failVec[FL_LONG]); // R4

  AST_NOISE_WITH_LONG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failVec[FL_NOISE]) |-> failVec[FL_LONG]); // R5

  AST_STUCK_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && haveWord && wordIn == prevWord) |=> failVec[FL_STUCK]); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clearFlags |=> ((failVec & $past(failVec)) == $past(failVec))); // R8

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && haveBit && bitIn != prevBit) |=> (runLen == RUN_W'(1))); // R10

endmodule

// File: rtl/rng_health_monitor.sv
module rng_health_monitor
  import rng_hm_pkg::*;
#(
  parameter int BLOCK_BITS   = 20000,
  parameter int WORD_W       = 32,
  parameter int MONO_LO      = 9654,
  parameter int MONO_HI      = 10346,
  parameter int POKER_CNT_LO = 0,
  parameter int POKER_CNT_HI = 5000,
  parameter int POKER_SQ_LO  = 1562822,
  parameter int POKER_SQ_HI  = 1580437,
  parameter int RUN_BINS     = 6,
  parameter int RUN_LO [RUN_BINS] = '{2267, 1079, 502, 223, 90, 90},
  parameter int RUN_HI [RUN_BINS] = '{2733, 1421, 748, 402, 223, 223},
  parameter int LONG_RUN     = 34,
  parameter int NOISE_RUN    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearFlags,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output logic              failMonobit,
  output logic              failPoker,
  output logic              failRuns,
  output logic              failLongRun,
  output logic              failNoise,
  output logic              failStuck
);

  ctlStrobe_t          strobe;
  logic [FLAG_CNT-1:0] failVec;

  rng_hm_control #(
    .BLOCK_BITS(BLOCK_BITS)
  ) uControl (
    .clk     (clk),
    .rstN    (rstN),
    .bitValid(bitValid),
    .strobe  (strobe)
  );

  rng_hm_datapath #(
    .BLOCK_BITS  (BLOCK_BITS),
    .WORD_W      (WORD_W),
    .MONO_LO     (MONO_LO),
    .MONO_HI     (MONO_HI),
    .POKER_CNT_LO(POKER_CNT_LO),
    .POKER_CNT_HI(POKER_CNT_HI),
    .POKER_SQ_LO (POKER_SQ_LO),
    .POKER_SQ_HI (POKER_SQ_HI),
    .RUN_BINS    (RUN_BINS),
    .RUN_LO      (RUN_LO),
    .RUN_HI      (RUN_HI),
    .LONG_RUN    (LONG_RUN),
    .NOISE_RUN   (NOISE_RUN)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clearFlags(clearFlags),
    .bitValid  (bitValid),
    .bitIn     (bitIn),
    .wordValid (wordValid),
    .wordIn    (wordIn),
    .failVec   (failVec)
  );

  assign failMonobit = failVec[FL_MONO];
  assign failPoker   = failVec[FL_POKER];
  assign failRuns    = failVec[FL_RUNS];
  assign failLongRun = failVec[FL_LONG];
  assign failNoise   = failVec[FL_NOISE];
  assign failStuck   = failVec[FL_STUCK];

endmodule

// File: tb/tb_rng_health_monitor.sv
module tb_rng_health_monitor;

  localparam int BLK   = 64;
  localparam int MLO   = 24;
  localparam int MHI   = 40;
  localparam int PLO   = 0;
  localparam int PHI   = 3;
  localparam int SLO   = 15;
  localparam int SHI   = 40;
  localparam int NB    = 6;
  localparam int RLO [NB] = '{4, 1, 0, 0, 0, 0};
  localparam int RHI [NB] = '{24, 12, 8, 6, 4, 4};
  localparam int LRUN  = 34;
  localparam int NRUN  = 48;
  localparam int GAP   = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearFlags = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic        failMonobit, failPoker, failRuns, failLongRun, failNoise, failStuck;

  always #10 clk = ~clk;

  rng_health_monitor #(
    .BLOCK_BITS(BLK), .WORD_W(32), .MONO_LO(MLO), .MONO_HI(MHI),
    .POKER_CNT_LO(PLO), .POKER_CNT_HI(PHI), .POKER_SQ_LO(SLO), .POKER_SQ_HI(SHI),
    .RUN_BINS(NB), .RUN_LO(RLO), .RUN_HI(RHI), .LONG_RUN(LRUN), .NOISE_RUN(NRUN)
  ) dut (
    .clk(clk), .rstN(rstN), .clearFlags(clearFlags), .bitValid(bitValid), .bitIn(bitIn),
    .wordValid(wordValid), .wordIn(wordIn), .failMonobit(failMonobit), .failPoker(failPoker),
    .failRuns(failRuns), .failLongRun(failLongRun), .failNoise(failNoise), .failStuck(failStuck)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // reference model state
  logic [5:0]  expFlags = '0;
  int          mRunLen = 0;
  bit          mHaveBit = 0;
  logic        mPrevBit = 1'b0;
  bit          mHaveWord = 0;
  logic [31:0] mPrevWord = '0;
  int          busyLeft = 0;
  int          winCnt = 0;
  logic        wb [BLK];
  logic [2:0]  pending = '0;

  function automatic string tagOf(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Scores the stored window: bit0 ones balance, bit1 patterns, bit2 runs.
  function automatic logic [2:0] scoreWindow();
    int ones = 0;
    int pc [16];
    int sq = 0;
    int binO [NB];
    int binZ [NB];
    int i = 0;
    int j;
    int len;
    int bin;
    logic [2:0] v = '0;
    for (int k = 0; k < 16; k++) pc[k] = 0;
    for (int k = 0; k < NB; k++) begin binO[k] = 0; binZ[k] = 0; end
    for (int k = 0; k < BLK; k++) if (wb[k]) ones++;
    for (int n = 0; n < BLK / 4; n++)
      pc[8 * int'(wb[4*n]) + 4 * int'(wb[4*n+1]) + 2 * int'(wb[4*n+2]) + int'(wb[4*n+3])]++;
    for (int k = 0; k < 16; k++) begin
      sq += pc[k] * pc[k];
      if (pc[k] < PLO || pc[k] > PHI) v[1] = 1'b1;
    end
    if (!(sq > SLO && sq < SHI)) v[1] = 1'b1;
    if (!(ones > MLO && ones < MHI)) v[0] = 1'b1;
    while (i < BLK) begin
      j = i;
      while (j + 1 < BLK && wb[j+1] == wb[i]) j++;
      len = j - i + 1;
      bin = (len >= NB) ? NB - 1 : len - 1;
      if (wb[i]) binO[bin]++; else binZ[bin]++;
      i = j + 1;
    end
    for (int k = 0; k < NB; k++)
      if (binO[k] < RLO[k] || binO[k] > RHI[k] || binZ[k] < RLO[k] || binZ[k] > RHI[k]) v[2] = 1'b1;
    return v;
  endfunction

  task automatic modelEdge(input logic bv, input logic b, input logic wv,
                           input logic [31:0] w, input logic clr);
    logic [5:0] sets = '0;
    if (bv) begin
      mRunLen  = (mHaveBit && b == mPrevBit) ? mRunLen + 1 : 1;
      mPrevBit = b;
      mHaveBit = 1;
      if (mRunLen >= LRUN) sets[3] = 1'b1;
      if (mRunLen >= NRUN) sets[4] = 1'b1;
    end
    // R7: bits during the scoring gap are excluded from windows
    if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0) sets[2:0] = pending;
    end else if (bv) begin
      wb[winCnt] = b;
      winCnt++;
      if (winCnt == BLK) begin
        pending  = scoreWindow();
        winCnt   = 0;
        busyLeft = GAP;
      end
    end
    if (wv) begin
      if (mHaveWord && w == mPrevWord) sets[5] = 1'b1;
      mPrevWord = w;
      mHaveWord = 1;
    end
    expFlags = (clr ? 6'b0 : expFlags) | sets;
  endtask

  function automatic logic [5:0] dutFlags();
    return {failStuck, failNoise, failLongRun, failRuns, failPoker, failMonobit};
  endfunction

  task automatic compareAll();
    logic [5:0] a = dutFlags();
    for (int k = 0; k < 6; k++) begin
      nChecks++;
      if (a[k] !== expFlags[k]) begin
        nFail++;
        $display("FAIL %s flag %0d: actual %b expected %b at %0t", tagOf(k), k, a[k], expFlags[k], $time);
      end
    end
  endtask

  task automatic checkNow(input string tag, input logic [5:0] want);
    nChecks++;
    if (dutFlags() !== want) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, dutFlags(), want);
    end
  endtask

  task automatic cyc(input logic bv, input logic b, input logic wv,
                     input logic [31:0] w, input logic clr);
    bitValid = bv; bitIn = b; wordValid = wv; wordIn = w; clearFlags = clr;
    @(posedge clk);
    modelEdge(bv, b, wv, w, clr);
    @(negedge clk);
    compareAll();
  endtask

  task automatic bits(input logic b, input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, b, 1'b0, '0, 1'b0);
  endtask

  task automatic clearPulse();
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    checkNow("R9 reset", 6'b0);               // R9: flags low in reset
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R4: 33 identical bits do not flag, 34 do
    bits(1'b1, 33);
    checkNow("R4 below limit", expFlags);
    bits(1'b0, LRUN);
    checkNow("R4 at limit", expFlags);

    // R8: clear drops flags, stay clear with no new event
    clearPulse();
    checkNow("R8 clear", expFlags);
    cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);

    // R5 / R10: very long run, clear mid-run, run keeps flagging (saturation)
    bits(1'b1, 70);
    clearPulse();
    bits(1'b1, 40);
    checkNow("R10 saturated run", expFlags);
    bits(1'b0, 3);

    // R6: repeated word, with idle cycles in between
    cyc(1'b0, 1'b0, 1'b1, 32'hA5A5_0001, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 32'hA5A5_0002, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 32'hA5A5_0002, 1'b0);
    checkNow("R6 repeat", expFlags);
    clearPulse();

    // R3: alternating pattern across whole windows overflows the length-1 bins
    for (int i = 0; i < 2 * BLK; i++) cyc(1'b1, logic'(i % 2), 1'b0, '0, 1'b0);
    repeat (GAP + 2) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
    checkNow("R3 alternating", expFlags);
    clearPulse();

    // R1 / R2 / R7: random streams with varied bias; bits arrive during scoring gaps too
    for (int seg = 0; seg < 40; seg++) begin
      int bias = (seg % 4 == 0) ? 90 : (seg % 4 == 1) ? 50 : (seg % 4 == 2) ? 30 : 55;
      for (int i = 0; i < 120; i++) begin
        logic bv = ($urandom % 4) != 0;
        logic b  = ($urandom % 100) < bias;
        logic wv = ($urandom % 8) == 0;
        logic [31:0] w = 32'h1000 + ($urandom % 4);
        logic clr = ($urandom % 150) == 0;
        cyc(bv, b, wv, w, clr);
      end
      checkNow("R1 R2 R7 segment", expFlags);
    end

    // R1: a window of all zeros fails balance and patterns
    clearPulse();
    repeat (BLK + GAP + 2) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0);
    checkNow("R1 all zeros", expFlags);

    repeat (4) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
    finish();
  end

endmodule